// File: doc/BRIEF.md
# Gated Timer/Counter Channel

This block is a single timer/counter channel. On every enabled step it advances a count held in two bytes, a low byte and a high byte. A step comes from one of two sources. The first is an internal tick enable supplied by an upstream prescaler. The second is a high-to-low transition on an external count pin, sampled on ticks. A run bit starts and stops counting. When the gate bit is set, counting also needs an external gate pin to be high, so hardware can measure the width of a pulse on that pin.

Two mode bits choose how the count wraps. The options are a 13-bit counter, a 16-bit counter, an 8-bit counter that reloads from the high byte, and a stopped channel. Each wrap sets an overflow flag, which drives the interrupt request. The flag is cleared either by software through the register bus or by the interrupt controller's acknowledge.

A small synchronous register bus reaches the two count bytes, the mode register and the control register. Reads return data combinationally.

Top module: `gtc_timer`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and `irq` is low.
- R2: With the gate bit at 0, the run bit alone enables counting. With the gate bit at 1, a step is counted only while the run bit is 1 and `gate_pin` is high.
- R3: With the source bit at 0, every cycle with `tick_en` high is one step. With the source bit at 1, a step happens on a cycle with `tick_en` high when `cnt_pin` is 0 and the previous tick sampled it as 1.
- R4: `cnt_pin` is sampled only on ticks. Two consecutive ticks can never both produce an external step, so one held-low level counts once, and a pin change between ticks with no tick on the low level is not counted.
- R5: Mode 0 (mode bits 00) is a 13-bit counter. Low bits [4:0] count, and their carry increments the high byte. Low bits [7:5] keep their value. A step from high 0xFF with low [4:0] at 0x1F clears those 13 bits and is an overflow.
- R6: Mode 1 (mode bits 01) is a 16-bit counter, {high, low}. A step from 0xFFFF gives 0x0000 and is an overflow.
- R7: Mode 2 (mode bits 10) counts in the low byte only. A step from low 0xFF loads the low byte from the high byte and is an overflow.
- R8: Mode 3 (mode bits 11) holds both count bytes regardless of steps.
- R9: An overflow sets the flag at the same clock edge as the wrap. `irq` equals the flag. A control-register write stores bit 1 into the flag.
- R10: `irq_ack` clears the flag. An overflow in the same cycle wins over both an acknowledge and a control write.
- R11: A write to either count byte wins over a step in the same cycle. That step is dropped: neither byte increments and no overflow occurs.
- R12: Register addresses are 0 for the low byte, 1 for the high byte, 2 for mode, and 3 for control. The mode register holds bits [1:0] = mode, [2] = external source, [3] = gate. The control register holds [0] = run and [1] = flag. Unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Internal count tick, one cycle per tick |
| cnt_pin | input | 1 | External count pin |
| gate_pin | input | 1 | External gate level |
| irq_ack | input | 1 | Interrupt acknowledge, clears the flag |
| reg_addr | input | 2 | Register select |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for `reg_addr` |
| irq | output | 1 | Overflow interrupt request (the flag) |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a count-byte write and a counting step. The bench drives `tick_en` and a write strobe in the same cycle, once mid-count and once on the step that would wrap from 0xFFFF. It judges the outcome by the written byte holding, the other byte staying unchanged, and the flag staying clear. The second pair is an overflow and an interrupt acknowledge. The bench holds `irq_ack` high through the wrapping step and expects the flag to remain set.

// File: rtl/gtc_pkg.sv
// Shared types and register layout for the gated timer/counter channel.
// Assumes an 8-bit data bus and a 2-bit register address.
package gtc_pkg;

    typedef enum logic [1:0] {
        MODE_13   = 2'd0,
        MODE_16   = 2'd1,
        MODE_8R   = 2'd2,
        MODE_STOP = 2'd3
    } cnt_mode_e;

    localparam int ADDR_W   = 2;
    localparam logic [ADDR_W-1:0] ADDR_LO   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_HI   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd3;

    localparam int MB_SRC  = 2;
    localparam int MB_GATE = 3;
    localparam int CB_RUN  = 0;
    localparam int CB_FLAG = 1;

endpackage

// File: rtl/gtc_step_src.sv
// Step source: picks the internal tick or a falling edge on the external pin
// and qualifies it with the run bit and the optional gate pin.
// Assumes cnt_pin is already synchronised and tick_en lasts one cycle per tick.
module gtc_step_src (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic cnt_pin,
    input  logic sel_ext,
    input  logic gate_en,
    input  logic gate_pin,
    input  logic run,
    output logic step
);
    logic pin_q;
    logic ext_fall;
    logic run_ok;

    // Capture the count pin on every tick so a 1-then-0 pattern can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n)       pin_q <= 1'b0;
        else if (tick_en) pin_q <= cnt_pin;
    end

    // Form the external event, the run qualification and the selected step.
    always_comb begin
        ext_fall = tick_en & pin_q & ~cnt_pin;
        run_ok   = run & (~gate_en | gate_pin);
        step     = run_ok & (sel_ext ? ext_fall : tick_en);
    end

    // R4: two external events never come on consecutive cycles.
    p_ext_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ext_fall |=> !ext_fall);

endmodule

// File: rtl/gtc_count_core.sv
// Count core: two count bytes with 13-bit, 16-bit, 8-bit auto-reload and
// stopped modes. A byte write wins over a step and drops that step.
// Assumes PRE_W < DATA_W.
module gtc_count_core
    import gtc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PRE_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  cnt_mode_e         mode,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] cnt_lo,
    output logic [DATA_W-1:0] cnt_hi,
    output logic              wrap
);
    logic [DATA_W-1:0] lo_q, hi_q, lo_n, hi_n;
    logic              wrap_c;
    logic              wr_any;

    // Next count value and wrap condition for the selected mode.
    always_comb begin
        lo_n   = lo_q;
        hi_n   = hi_q;
        wrap_c = 1'b0;
        unique case (mode)
            MODE_13: begin
                if (&lo_q[PRE_W-1:0]) begin
                    lo_n[PRE_W-1:0] = '0;
                    hi_n            = hi_q + 1'b1;
                    wrap_c          = &hi_q;
                end else begin
                    lo_n[PRE_W-1:0] = lo_q[PRE_W-1:0] + 1'b1;
                end
            end
            MODE_16: begin
                {hi_n, lo_n} = {hi_q, lo_q} + 1'b1;
                wrap_c       = &{hi_q, lo_q};
            end
            MODE_8R: begin
                if (&lo_q) begin
                    lo_n   = hi_q;
                    wrap_c = 1'b1;
                end else begin
                    lo_n = lo_q + 1'b1;
                end
            end
            default: ;
        endcase
    end

    assign wr_any = wr_lo | wr_hi;

    // Update the count bytes: a bus write first, otherwise a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else if (wr_any) begin
            if (wr_lo) lo_q <= wr_data;
            if (wr_hi) hi_q <= wr_data;
        end else if (step) begin
            lo_q <= lo_n;
            hi_q <= hi_n;
        end
    end

    assign wrap   = step & ~wr_any & wrap_c;
    assign cnt_lo = lo_q;
    assign cnt_hi = hi_q;

    // R6: a 16-bit wrap leaves the count at zero.
    p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && mode == MODE_16) |=> (lo_q == '0 && hi_q == '0));

    // R7: an 8-bit wrap reloads the low byte from the high byte.
    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && mode == MODE_8R) |=> (lo_q == $past(hi_q)));

    // R8: stopped mode holds the count unless it is written.
    p_mode3_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_STOP && !wr_any) |=> $stable({hi_q, lo_q}));

    // R11: a low-byte write lands even when a step is present.
    p_cnt_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (lo_q == $past(wr_data)));

endmodule

// File: rtl/gtc_timer.sv
// Gated timer/counter channel top: register bus, mode and control bits,
// overflow flag with acknowledge, and the step source plus count core.
// Assumes single-cycle synchronous writes and combinational reads.
module gtc_timer
    import gtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        cnt_pin,
    input  logic        gate_pin,
    input  logic        irq_ack,
    input  logic [1:0]  reg_addr,
    input  logic        wr_en,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    output logic        irq
);
    localparam int DATA_W = 8;
    localparam int PRE_W  = 5;
    localparam int MODE_W = 2;

    logic [MODE_W-1:0] mode_q;
    logic              src_q, gate_q, run_q, flag_q;
    logic              wr_lo, wr_hi, wr_mode, wr_ctrl;
    logic              step, wrap;
    logic [DATA_W-1:0] cnt_lo, cnt_hi;

    // Decode register writes.
    always_comb begin
        wr_lo   = wr_en && reg_addr == ADDR_LO;
        wr_hi   = wr_en && reg_addr == ADDR_HI;
        wr_mode = wr_en && reg_addr == ADDR_MODE;
        wr_ctrl = wr_en && reg_addr == ADDR_CTRL;
    end

    // Mode and control bits held for software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            src_q  <= 1'b0;
            gate_q <= 1'b0;
            run_q  <= 1'b0;
        end else begin
            if (wr_mode) begin
                mode_q <= wr_data[MODE_W-1:0];
                src_q  <= wr_data[MB_SRC];
                gate_q <= wr_data[MB_GATE];
            end
            if (wr_ctrl) run_q <= wr_data[CB_RUN];
        end
    end

    // Overflow flag: a wrap wins, then a software write, then the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (wrap)    flag_q <= 1'b1;
        else if (wr_ctrl) flag_q <= wr_data[CB_FLAG];
        else if (irq_ack) flag_q <= 1'b0;
    end

    gtc_step_src u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .cnt_pin  (cnt_pin),
        .sel_ext  (src_q),
        .gate_en  (gate_q),
        .gate_pin (gate_pin),
        .run      (run_q),
        .step     (step)
    );

    gtc_count_core #(.DATA_W(DATA_W), .PRE_W(PRE_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .mode    (cnt_mode_e'(mode_q)),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_data (wr_data),
        .cnt_lo  (cnt_lo),
        .cnt_hi  (cnt_hi),
        .wrap    (wrap)
    );

    // Read multiplexer; unused bits return zero.
    always_comb begin
        unique case (reg_addr)
            ADDR_LO:   rd_data = cnt_lo;
            ADDR_HI:   rd_data = cnt_hi;
            ADDR_MODE: rd_data = {4'b0, gate_q, src_q, mode_q};
            default:   rd_data = {6'b0, flag_q, run_q};
        endcase
    end

    assign irq = flag_q;

    // R2: with the gate set and the gate pin low, the count holds unless written.
    p_gate_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && !gate_pin && !wr_lo && !wr_hi) |=> $stable({cnt_hi, cnt_lo}));

    // R9: a wrap leaves the flag set.
    p_ovf_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag_q);

    // R10: an acknowledge with no wrap and no control write clears the flag.
    p_ack_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !wrap && !wr_ctrl) |=> !flag_q);

endmodule

// File: tb/gtc_timer_test.sv
`timescale 1ns/1ps
module gtc_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0, cnt_pin = 1'b0, gate_pin = 1'b0, irq_ack = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    gtc_timer uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt_pin(cnt_pin),
        .gate_pin(gate_pin), .irq_ack(irq_ack), .reg_addr(reg_addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    typedef struct packed {
        logic [1:0] mode;
        logic       ext;
        logic       gate;
        logic       gpin;
        logic       run;
        logic [7:0] hi;
        logic [7:0] lo;
        logic [7:0] n;
        logic [7:0] ehi;
        logic [7:0] elo;
        logic       ef;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 8'd5,  8'h00, 8'h05, 1'b0},
        '{2'd1, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 8'hFE, 8'd3,  8'h00, 8'h01, 1'b1},
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'hE0, 8'd33, 8'h01, 8'hE1, 1'b0},
        '{2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 8'hFF, 8'd1,  8'h00, 8'hE0, 1'b1},
        '{2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 8'h80, 8'hFE, 8'd3,  8'h80, 8'h81, 1'b1},
        '{2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 8'h12, 8'h34, 8'd10, 8'h12, 8'h34, 1'b0},
        '{2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, 8'd6,  8'h00, 8'h00, 1'b0},
        '{2'd1, 1'b0, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 8'd6,  8'h00, 8'h06, 1'b0},
        '{2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'd6,  8'h00, 8'h00, 1'b0},
        '{2'd1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 8'd4,  8'h00, 8'h04, 1'b0},
        '{2'd1, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'h00, 8'd4,  8'h00, 8'h00, 1'b0}
    };

    function automatic string vtag(int i);
        case (i)
            0:  return "R3/R6 internal 16-bit count";
            1:  return "R6/R9 16-bit wrap";
            2:  return "R5 13-bit carry";
            3:  return "R5/R9 13-bit wrap";
            4:  return "R7/R9 8-bit reload";
            5:  return "R8 stopped mode";
            6:  return "R2 gate pin low";
            7:  return "R2 gate pin high";
            8:  return "R2 run off";
            9:  return "R3/R4 external pulses";
            default: return "R2 external gated off";
        endcase
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = rd_data;
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
        end
        @(negedge clk); tick_en = 1'b0;
    endtask

    task automatic pulses(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1; cnt_pin = 1'b1;
            @(negedge clk); cnt_pin = 1'b0;
        end
        @(negedge clk); tick_en = 1'b0;
    endtask

    task automatic setup(logic [1:0] m, logic ext, logic gt, logic [7:0] hi, logic [7:0] lo);
        wr(2'd3, 8'h00);
        wr(2'd2, {4'b0, gt, ext, m});
        wr(2'd0, lo);
        wr(2'd1, hi);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] d, h, c;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R12: reset state of every register.
        rd(2'd0, d); check("R1 low byte after reset", {8'h0, d}, 16'h0);
        rd(2'd1, d); check("R1 high byte after reset", {8'h0, d}, 16'h0);
        rd(2'd2, d); check("R1 mode after reset", {8'h0, d}, 16'h0);
        rd(2'd3, d); check("R1 control after reset", {8'h0, d}, 16'h0);
        check("R1 irq after reset", {15'h0, irq}, 16'h0);

        // R12: mode register field positions and unused bits.
        wr(2'd2, 8'hFF);
        rd(2'd2, d); check("R12 mode readback", {8'h0, d}, 16'h000F);

        // Table-driven walk over modes, sources and gating.
        for (int i = 0; i < NV; i++) begin
            vec_t v = VECS[i];
            setup(v.mode, v.ext, v.gate, v.hi, v.lo);
            gate_pin = v.gpin;
            cnt_pin  = 1'b0;
            wr(2'd3, {7'b0, v.run});
            if (v.ext) pulses(int'(v.n)); else ticks(int'(v.n));
            rd(2'd0, d); rd(2'd1, h); rd(2'd3, c);
            check({vtag(i), " count"}, {h, d}, {v.ehi, v.elo});
            check({vtag(i), " flag"}, {15'h0, c[1]}, {15'h0, v.ef});
            check({vtag(i), " irq"}, {15'h0, irq}, {15'h0, v.ef});
        end
        gate_pin = 1'b0;

        // R4: a pin change between ticks is invisible; a held low counts once.
        setup(2'd1, 1'b1, 1'b0, 8'h00, 8'h00);
        wr(2'd3, 8'h01);
        @(negedge clk); tick_en = 1'b1; cnt_pin = 1'b1;
        @(negedge clk); tick_en = 1'b0; cnt_pin = 1'b0;
        @(negedge clk); cnt_pin = 1'b1;
        @(negedge clk); tick_en = 1'b1;
        @(negedge clk); tick_en = 1'b0;
        rd(2'd0, d); check("R4 low between ticks not counted", {8'h0, d}, 16'h0);
        @(negedge clk); tick_en = 1'b1; cnt_pin = 1'b0;
        repeat (5) @(negedge clk);
        tick_en = 1'b0;
        rd(2'd0, d); check("R4 held low counts once", {8'h0, d}, 16'h1);

        // R9: software write sets and clears the flag.
        wr(2'd3, 8'h02);
        check("R9 software set flag", {15'h0, irq}, 16'h1);
        wr(2'd3, 8'h00);
        check("R9 software clear flag", {15'h0, irq}, 16'h0);

        // R10: acknowledge clears a flag set by overflow.
        setup(2'd1, 1'b0, 1'b0, 8'hFF, 8'hFF);
        wr(2'd3, 8'h01);
        ticks(1);
        check("R10 flag set before ack", {15'h0, irq}, 16'h1);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        check("R10 ack clears flag", {15'h0, irq}, 16'h0);

        // R10: an overflow in the same cycle as an acknowledge wins.
        setup(2'd1, 1'b0, 1'b0, 8'hFF, 8'hFF);
        wr(2'd3, 8'h01);
        @(negedge clk); tick_en = 1'b1; irq_ack = 1'b1;
        @(negedge clk); tick_en = 1'b0; irq_ack = 1'b0;
        check("R10 overflow beats ack", {15'h0, irq}, 16'h1);

        // R11: a low-byte write in the same cycle as a step wins.
        setup(2'd1, 1'b0, 1'b0, 8'h00, 8'h10);
        wr(2'd3, 8'h01);
        @(negedge clk); tick_en = 1'b1; reg_addr = 2'd0; wr_data = 8'h40; wr_en = 1'b1;
        @(negedge clk); tick_en = 1'b0; wr_en = 1'b0;
        rd(2'd0, d); rd(2'd1, h);
        check("R11 write beats step", {h, d}, 16'h0040);
        ticks(1);
        rd(2'd0, d); check("R11 counting resumes after write", {8'h0, d}, 16'h41);

        // R11: a high-byte write drops a step that would wrap.
        setup(2'd1, 1'b0, 1'b0, 8'hFF, 8'hFF);
        wr(2'd3, 8'h01);
        @(negedge clk); tick_en = 1'b1; reg_addr = 2'd1; wr_data = 8'h12; wr_en = 1'b1;
        @(negedge clk); tick_en = 1'b0; wr_en = 1'b0;
        rd(2'd0, d); rd(2'd1, h);
        check("R11 write drops wrapping step", {h, d}, 16'h12FF);
        check("R11 no overflow from dropped step", {15'h0, irq}, 16'h0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule